// File: doc/BRIEF.md
# Statically Scheduled Arithmetic Core

This block is a small arithmetic engine that runs a fixed program held in a ROM. Nothing in the hardware tracks dependencies. The program was arranged ahead of time so that every operand is ready when it is read, and every result lands exactly when the schedule expects it. A data RAM acts as the register file. On reset it is loaded from a parameter, and it keeps its contents from one run to the next, so results can accumulate across runs.

Each ROM word names an operation and two operand fields. It also carries a destination field, called the exit field. The exit field does not belong to the operation it travels with. It names the register that receives whichever result finishes in the cycle that word issues. Each operation kind has a fixed latency. Results come out of the one-cycle path and the multiplier pipeline, and they are written back under the control of the exit field.

A host pulses `start` while `ready` is high. The core then runs every ROM word once, one per cycle, and goes back to idle. There is no back-pressure on either data side. `in_data` is sampled in the cycle an input instruction issues, so the producer must present it in that cycle. A beat on `out_valid` lasts one cycle and cannot be stalled, so the consumer must take every beat.

Top module: `stat_sched_cpu`

## Requirements
- R1: After reset `ready` is 1, `out_valid` is 0, `out_data` is 0, and data register i holds word i of the RAM initial image.
- R2: When `start` is high in a cycle where `ready` is high, `ready` is 0 from the next cycle, for exactly ROM_DEPTH cycles, while ROM words 0 to ROM_DEPTH-1 issue one per cycle. `ready` then returns to 1. `start` has no effect while `ready` is 0.
- R3: The instruction word layout is as follows. Bits [2:0] hold the opcode: 0 nop, 1 add, 2 sub, 3 mul, 4 shift, 5 copy, 6 input, 7 output. Next above is operand field A, then operand field B, then the exit field, each REG_W = clog2(RAM_DEPTH) bits wide. A legal program never lets two results complete in the same cycle.
- R4: Add and sub produce reg[A] + reg[B] and reg[A] - reg[B], wrapping in two's complement. The result completes one cycle after issue.
- R5: Mul produces the low DATA_W bits of the signed product reg[A] * reg[B]. The result completes MUL_STAGES cycles after issue.
- R6: Shift takes its amount from field A as a signed REG_W-bit immediate and its operand from reg[B]. A positive amount shifts left. A negative amount shifts arithmetically right by its magnitude. The latency is one cycle.
- R7: Copy yields reg[A]. Input yields the value on `in_data` in its issue cycle. Both have a latency of one cycle.
- R8: Output drives reg[A] on `out_data` with `out_valid` high in the cycle after issue only. `out_data` holds its value when no output instruction issued.
- R9: A result that completes in cycle t is written to reg[exit of the word issued in t] at the end of t. An instruction issued in t still reads the old value (no forwarding). An instruction issued in t+1 reads the new value.
- R10: Register 0 is scratch. A completing result with exit field 0 leaves registers 1 and above unchanged.
- R11: Data registers keep their values between runs. `start` does not reload the initial image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when ready |
| ready | output | 1 | Core idle, accepts start |
| in_data | input | DATA_W | Data sampled by input instructions |
| out_data | output | DATA_W | Value from the last output instruction |
| out_valid | output | 1 | One-cycle strobe for out_data |

## Verification
The hardest situation to reach from the ports is the write-back timing. A result must reach the register named by a later word's exit field. It must be invisible to a read in its own completion cycle and visible one cycle later. It must also be discarded when that exit field is zero. Only output instructions can observe any of this. The bench program therefore places a read of a register in the very cycle that register is rewritten, then reads it again one cycle later. It also drops completing results into register 0 and then prints the registers those results could have hit. Randomised input words, over many back-to-back runs, exercise wrap-around in the arithmetic and accumulation across runs. Every value is compared with a bench-side scheduled model.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ADD    = 3'd1,
    OP_SUB    = 3'd2,
    OP_MUL    = 3'd3,
    OP_SHIFT  = 3'd4,
    OP_COPY   = 3'd5,
    OP_INPUT  = 3'd6,
    OP_OUTPUT = 3'd7
  } op_e;

  localparam int OPC_W = 3;
endpackage

// File: rtl/ssc_fetch.sv
module ssc_fetch
  import ssc_pkg::*;
#(
  parameter int ROM_DEPTH = 16,
  parameter int REG_W = 4,
  parameter int INSN_W = OPC_W + 3 * REG_W,
  parameter logic [ROM_DEPTH*INSN_W-1:0] ROM_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             ready,
  output logic             issue,
  output op_e              op,
  output logic [REG_W-1:0] fld_a,
  output logic [REG_W-1:0] fld_b,
  output logic [REG_W-1:0] fld_exit
);
  localparam int PC_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(ROM_DEPTH - 1);

  logic [INSN_W-1:0] rom [ROM_DEPTH];
  logic [PC_W-1:0]   pc;
  logic              running;
  logic [INSN_W-1:0] word;

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign rom[g] = ROM_INIT[g*INSN_W +: INSN_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
    end else if (!running) begin
      running <= start;
      pc      <= '0;
    end else if (pc == PC_LAST) begin
      running <= 1'b0;
      pc      <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end

  assign word     = running ? rom[pc] : '0;
  assign op       = op_e'(word[OPC_W-1:0]);
  assign fld_a    = word[OPC_W +: REG_W];
  assign fld_b    = word[OPC_W+REG_W +: REG_W];
  assign fld_exit = word[OPC_W+2*REG_W +: REG_W];
  assign ready    = !running;
  assign issue    = running;
endmodule

// File: rtl/ssc_regfile.sv
module ssc_regfile #(
  parameter int DEPTH = 16,
  parameter int DATA_W = 32,
  parameter int AW = 4,
  parameter logic [DEPTH*DATA_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= INIT[g*DATA_W +: DATA_W];
      else if (we && wa == AW'(g))
        mem[g] <= wd;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/ssc_exec.sv
module ssc_exec
  import ssc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W = 4,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  op_e               op,
  input  logic [REG_W-1:0]  imm,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] in_data,
  output logic              alu_done,
  output logic [DATA_W-1:0] alu_res,
  output logic              mul_done,
  output logic [DATA_W-1:0] mul_res,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic signed [REG_W-1:0] amt;
  logic [REG_W-1:0]        mag;
  logic [DATA_W-1:0]       shifted;
  logic [DATA_W-1:0]       alu_next;
  logic                    lat1;
  logic [DATA_W-1:0]       mul_lo;
  logic [MUL_STAGES-1:0]   ms_v;
  logic [DATA_W-1:0]       ms_d [MUL_STAGES];

  assign amt = $signed(imm);
  assign mag = amt[REG_W-1] ? REG_W'(-amt) : imm;

  always_comb begin
    if (amt[REG_W-1])
      shifted = $signed(opb) >>> mag;
    else
      shifted = opb << mag;
  end

  always_comb begin
    case (op)
      OP_ADD:   alu_next = opa + opb;
      OP_SUB:   alu_next = opa - opb;
      OP_COPY:  alu_next = opa;
      OP_INPUT: alu_next = in_data;
      OP_SHIFT: alu_next = shifted;
      default:  alu_next = '0;
    endcase
  end

  assign lat1 = issue && (op inside {OP_ADD, OP_SUB, OP_COPY, OP_INPUT, OP_SHIFT});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_done <= 1'b0;
      alu_res  <= '0;
    end else begin
      alu_done <= lat1;
      if (lat1)
        alu_res <= alu_next;
    end
  end

  assign mul_lo = opa * opb;

  for (genvar s = 0; s < MUL_STAGES; s++) begin : g_mul
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ms_v[0] <= 1'b0;
          ms_d[0] <= '0;
        end else begin
          ms_v[0] <= issue && (op == OP_MUL);
          ms_d[0] <= mul_lo;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ms_v[s] <= 1'b0;
          ms_d[s] <= '0;
        end else begin
          ms_v[s] <= ms_v[s-1];
          ms_d[s] <= ms_d[s-1];
        end
      end
    end
  end

  assign mul_done = ms_v[MUL_STAGES-1];
  assign mul_res  = ms_d[MUL_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= issue && (op == OP_OUTPUT);
      if (issue && (op == OP_OUTPUT))
        out_data <= opa;
    end
  end
endmodule

// File: rtl/stat_sched_cpu.sv
module stat_sched_cpu
  import ssc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MUL_STAGES = 2,
  parameter int ROM_DEPTH = 16,
  parameter int RAM_DEPTH = 16,
  localparam int REG_W = $clog2(RAM_DEPTH),
  localparam int INSN_W = OPC_W + 3 * REG_W,
  parameter logic [ROM_DEPTH*INSN_W-1:0] ROM_INIT = '0,
  parameter logic [RAM_DEPTH*DATA_W-1:0] RAM_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid
);
  logic              issue;
  op_e               op;
  logic [REG_W-1:0]  fld_a;
  logic [REG_W-1:0]  fld_b;
  logic [REG_W-1:0]  fld_exit;
  logic [DATA_W-1:0] opa;
  logic [DATA_W-1:0] opb;
  logic              alu_done;
  logic [DATA_W-1:0] alu_res;
  logic              mul_done;
  logic [DATA_W-1:0] mul_res;
  logic              wb_en;
  logic [DATA_W-1:0] wb_data;

  ssc_fetch #(
    .ROM_DEPTH(ROM_DEPTH),
    .REG_W    (REG_W),
    .INSN_W   (INSN_W),
    .ROM_INIT (ROM_INIT)
  ) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ready   (ready),
    .issue   (issue),
    .op      (op),
    .fld_a   (fld_a),
    .fld_b   (fld_b),
    .fld_exit(fld_exit)
  );

  ssc_regfile #(
    .DEPTH (RAM_DEPTH),
    .DATA_W(DATA_W),
    .AW    (REG_W),
    .INIT  (RAM_INIT)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .ra_a (fld_a),
    .ra_b (fld_b),
    .we   (wb_en),
    .wa   (fld_exit),
    .wd   (wb_data),
    .rd_a (opa),
    .rd_b (opb)
  );

  ssc_exec #(
    .DATA_W    (DATA_W),
    .REG_W     (REG_W),
    .MUL_STAGES(MUL_STAGES)
  ) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .op       (op),
    .imm      (fld_a),
    .opa      (opa),
    .opb      (opb),
    .in_data  (in_data),
    .alu_done (alu_done),
    .alu_res  (alu_res),
    .mul_done (mul_done),
    .mul_res  (mul_res),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  assign wb_en   = issue && (alu_done || mul_done);
  assign wb_data = alu_done ? alu_res : mul_res;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int DATA_W = 32,
  parameter int ROM_DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              alu_done,
  input logic              mul_done
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ready) busy_cnt <= 0;
    else                 busy_cnt <= busy_cnt + 1;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> !ready); // R2

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (busy_cnt == ROM_DEPTH)); // R2

  AST_OUT_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$past(ready)); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> (!out_valid && $stable(out_data))); // R8

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({alu_done, mul_done}) <= 1); // R3
endmodule

bind stat_sched_cpu ssc_checker #(
  .DATA_W   (DATA_W),
  .ROM_DEPTH(ROM_DEPTH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ready    (ready),
  .out_valid(out_valid),
  .out_data (out_data),
  .alu_done (alu_done),
  .mul_done (mul_done)
);

// File: tb/stat_sched_cpu_bench.sv
module stat_sched_cpu_bench;
  localparam int DW = 32;
  localparam int MS = 2;
  localparam int ROMD = 32;
  localparam int RAMD = 16;
  localparam int IW = 15;
  localparam int RUNS = 24;

  // R3 layout: {exit, B, A, opcode}
  function automatic logic [IW-1:0] enc(int op, int a, int b, int ex);
    logic [3:0] a4 = a[3:0];
    logic [3:0] b4 = b[3:0];
    logic [3:0] e4 = ex[3:0];
    logic [2:0] o3 = op[2:0];
    return {e4, b4, a4, o3};
  endfunction

  function automatic logic [IW-1:0] prog(int c);
    case (c)
      0:  return enc(7, 1, 0, 0);
      1:  return enc(6, 0, 0, 0);
      2:  return enc(6, 0, 0, 4);
      3:  return enc(3, 4, 2, 5);
      4:  return enc(7, 5, 0, 0);
      5:  return enc(1, 4, 5, 6);
      6:  return enc(2, 4, 5, 7);
      7:  return enc(4, 3, 4, 8);
      8:  return enc(4, 14, 5, 9);
      9:  return enc(5, 6, 0, 10);
      10: return enc(3, 7, 8, 11);
      11: return enc(7, 6, 0, 0);
      12: return enc(7, 7, 0, 12);
      13: return enc(7, 8, 0, 0);
      14: return enc(7, 9, 0, 0);
      15: return enc(7, 10, 0, 0);
      16: return enc(7, 11, 0, 0);
      17: return enc(7, 12, 0, 0);
      18: return enc(1, 15, 4, 0);
      19: return enc(1, 3, 3, 15);
      20: return enc(7, 15, 0, 0);
      21: return enc(4, 7, 2, 0);
      22: return enc(5, 1, 0, 13);
      23: return enc(7, 13, 0, 0);
      24: return enc(7, 3, 0, 0);
      25: return enc(4, 8, 2, 0);
      26: return enc(7, 14, 0, 14);
      27: return enc(7, 14, 0, 0);
      default: return enc(0, 0, 0, 0);
    endcase
  endfunction

  function automatic logic [ROMD*IW-1:0] build_rom();
    logic [ROMD*IW-1:0] v = '0;
    for (int c = 0; c < ROMD; c++) v[c*IW +: IW] = prog(c);
    return v;
  endfunction

  function automatic logic [DW-1:0] init_word(int i);
    case (i)
      1: return 32'd7;
      2: return -32'sd3;
      3: return 32'd1000;
      13: return 32'd11;
      14: return 32'd22;
      15: return 32'd5;
      default: return 32'(100 + i);
    endcase
  endfunction

  function automatic logic [RAMD*DW-1:0] build_ram();
    logic [RAMD*DW-1:0] v = '0;
    for (int i = 0; i < RAMD; i++) v[i*DW +: DW] = init_word(i);
    return v;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R1";
      4, 16: return "R7";
      11, 17: return "R5";
      12, 13: return "R4";
      14, 15, 27: return "R6";
      20: return "R11";
      23, 24: return "R10";
      26: return "R9";
      default: return "R8";
    endcase
  endfunction

  localparam logic [ROMD*IW-1:0] ROM_IMG = build_rom();
  localparam logic [RAMD*DW-1:0] RAM_IMG = build_ram();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          ready;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_reg [RAMD];
  logic [DW-1:0] ind [ROMD];
  logic          exp_v [ROMD+1];
  logic [DW-1:0] exp_d [ROMD+1];

  always #2.5 clk = ~clk;

  stat_sched_cpu #(
    .DATA_W    (DW),
    .MUL_STAGES(MS),
    .ROM_DEPTH (ROMD),
    .RAM_DEPTH (RAMD),
    .ROM_INIT  (ROM_IMG),
    .RAM_INIT  (RAM_IMG)
  ) u_stat_sched_cpu (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready    (ready),
    .in_data  (in_data),
    .out_data (out_data),
    .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scheduled reference model built from R3 to R11
  task automatic model_run();
    logic          pv [ROMD+MS+1];
    logic [DW-1:0] pd [ROMD+MS+1];
    for (int i = 0; i <= ROMD + MS; i++) begin
      pv[i] = 0;
      pd[i] = '0;
    end
    for (int k = 0; k <= ROMD; k++) begin
      exp_v[k] = 0;
      exp_d[k] = '0;
    end
    for (int c = 0; c < ROMD; c++) begin
      logic [IW-1:0] w = ROM_IMG[c*IW +: IW];
      int op = int'(w[2:0]);
      int a = int'(w[6:3]);
      int b = int'(w[10:7]);
      int ex = int'(w[14:11]);
      logic [DW-1:0] va = m_reg[a];
      logic [DW-1:0] vb = m_reg[b];
      logic [DW-1:0] r;
      case (op)
        1: begin pv[c+1] = 1; pd[c+1] = va + vb; end
        2: begin pv[c+1] = 1; pd[c+1] = va - vb; end
        3: begin pv[c+MS] = 1; pd[c+MS] = va * vb; end
        4: begin
          if (a >= 8) r = $signed(vb) >>> (16 - a);
          else        r = vb << a;
          pv[c+1] = 1; pd[c+1] = r;
        end
        5: begin pv[c+1] = 1; pd[c+1] = va; end
        6: begin pv[c+1] = 1; pd[c+1] = ind[c]; end
        7: begin exp_v[c+1] = 1; exp_d[c+1] = va; end
        default: ;
      endcase
      if (pv[c]) m_reg[ex] = pd[c];
    end
  endtask

  task automatic run_once(input bit hold_start);
    for (int k = 0; k < ROMD; k++) ind[k] = $urandom;
    model_run();
    @(negedge clk);
    chk(ready === 1'b1, "R2 ready before start", DW'(ready), 1);
    start = 1'b1;
    in_data = $urandom;
    @(posedge clk);
    for (int k = 0; k <= ROMD; k++) begin
      @(negedge clk);
      if (k < ROMD) in_data = ind[k];
      start = hold_start && (k < ROMD);
      if (k == ROMD) start = 1'b0;
      chk(ready === (k == ROMD), "R2 ready", DW'(ready), DW'(k == ROMD));
      if (exp_v[k] || out_valid) begin
        chk(out_valid === exp_v[k], "R8 out_valid", DW'(out_valid), DW'(exp_v[k]));
        if (exp_v[k])
          chk(out_data === exp_d[k], tag_of(k - 1), out_data, exp_d[k]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < RAMD; i++) m_reg[i] = init_word(i);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R1 ready after reset", DW'(ready), 1);
    chk(out_valid === 1'b0, "R1 out_valid after reset", DW'(out_valid), 0);
    chk(out_data === '0, "R1 out_data after reset", out_data, 0);
    repeat (3) @(negedge clk);
    chk(out_data === '0, "R8 idle hold", out_data, 0);
    for (int r = 0; r < RUNS; r++) begin
      run_once(r == 3 || r == 10);
      if (r % 5 == 4) repeat (3) @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule